// File: doc/BRIEF.md
# Load Data Aligner with Protected Boot ROM

This block shapes the data returned on the load path before it reaches the register file. Each request carries an address, an access size and a signed flag, together with the raw 32-bit word that the selected memory region returned. The block first picks a source word for the request. That word is the raw data, a zero word for reads past the end of a ROM, a held boot-ROM word when the program counter runs outside the boot ROM, or the prefetched instruction for unmapped addresses. It then rotates the word or selects a lane according to the size and low address bits, extends the result to 32 bits, and presents it one clock later on a registered output.

The region is the address byte `addr[31:24]`. Region 0 is the boot ROM, region 4 is I/O, and regions 8 to 13 are cartridge ROM. Region 1 and every region from 16 upward are unmapped. All other regions pass the raw data through unchanged. The boot ROM is guarded by a word the block holds itself. That word is taken from `boot_ahead_word` when execution leaves region 0, and boot-ROM reads made from outside the boot ROM return it.

Top module: `load_aligner`

## Requirements
- R1: A word access (`rd_size` 2 or 3) returns the source word rotated right by 8 × `addr[1:0]` bits; the signed flag has no effect on it.
- R2: A halfword access (`rd_size` 1) takes the source halfword at bits [31:16] when `addr[1]` is 1 and at bits [15:0] otherwise, then rotates it right by 8 × `addr[0]` bits.
- R3: A byte access (`rd_size` 0) returns source byte lane `addr[1:0]` (lane n is bits [8n+7:8n]) with no rotation.
- R4: The block keeps a held boot word, which is 0 after reset. A register tracking whether the program counter was in region 0 is 1 after reset. In the first cycle `pc_region` is nonzero after being 0, the held word takes `boot_ahead_word`, and a boot-ROM read in that same cycle already sees the new value. In all other cycles the held word is unchanged. A region-0 read while `pc_region` is nonzero uses the held word as the source and ignores `rd_raw`.
- R5: A region-0 read while `pc_region` is 0 uses `rd_raw`. If the offset `addr[23:0]` is at or above `BOOT_BYTES` (default 16384), the source word is 0 instead.
- R6: A read in regions 8 to 13 whose offset `addr[24:0]` is at or above `cart_rom_bytes` has a source word of 0. Below that offset the source word is `rd_raw`.
- R7: A read in region 1 or in any region of 16 or more ignores `rd_raw`. With `exec_narrow` at 0 the source word is `open_bus_word`. With `exec_narrow` at 1 it is `open_bus_word[15:0]` placed in both halves. The source word is then shaped by size as usual.
- R8: For byte and halfword reads of region 4, `rd_raw[15:0]` carries the containing halfword. A byte read returns its low byte when `addr[0]` is 0 and its high byte when `addr[0]` is 1. A halfword read returns that halfword rotated by 8 × `addr[0]`. A word read of region 4 uses all of `rd_raw`.
- R9: When `rd_signed` is 0, byte results are zero-extended from bit 7 and halfword results from bit 15.
- R10: When `rd_signed` is 1, byte results are sign-extended from bit 7 and halfword results from bit 15, after rotation.
- R11: `out_valid` is 0 and `out_data` is 0 after reset. A request accepted on one clock edge appears on `out_valid` and `out_data` at the next edge. Without a request, `out_valid` is 0 and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Load request present this cycle |
| rd_addr | input | 32 | Byte address of the load |
| rd_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| rd_signed | input | 1 | Sign-extend byte and halfword results |
| rd_raw | input | 32 | Raw data from the addressed region |
| pc_region | input | 8 | Region of the executing program counter |
| exec_narrow | input | 1 | 1 when executing 16-bit instructions |
| boot_ahead_word | input | 32 | Boot-ROM word two instructions ahead of the PC |
| open_bus_word | input | 32 | Prefetched instruction (PC+8 word or PC+4 halfword in [15:0]) |
| cart_rom_bytes | input | 25 | Size in bytes of the loaded cartridge ROM |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Aligned and extended load data |

## Verification
The embedded properties check several rules on every cycle:
- the one-cycle latency and the hold of `out_data` on idle cycles;
- the zero results past the end of the boot ROM and of the cartridge ROM;
- zero and sign extension of byte and halfword results;
- the capture and hold of the boot word.

The exact rotation amounts, lane choice and halfword choice need the bench's scoreboard, which compares expected values for every access. The same is true of the open-bus duplication in narrow mode, the I/O byte selection, and the same-cycle bypass of the boot word on exit from region 0.

// File: rtl/ldal_pkg.sv
package ldal_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam int RG_BOOT      = 0;
  localparam int RG_HOLE      = 1;
  localparam int RG_IO        = 4;
  localparam int RG_CART_LO   = 8;
  localparam int RG_CART_HI   = 13;
  localparam int RG_MAP_LIMIT = 16;

  typedef enum logic [1:0] {
    SRC_RAW,
    SRC_ZERO,
    SRC_BOOT,
    SRC_OPEN
  } src_kind_e;

  function automatic logic [31:0] rotr32(input logic [31:0] w, input logic [1:0] bytes);
    logic [63:0] dbl;
    dbl = {w, w} >> (8 * bytes);
    return dbl[31:0];
  endfunction

  function automatic logic [15:0] rotr16(input logic [15:0] h, input logic bytes);
    return bytes ? {h[7:0], h[15:8]} : h;
  endfunction

endpackage

// File: rtl/ldal_boot_latch.sv
module ldal_boot_latch #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pc_in_boot,
  input  logic [DW-1:0] ahead_word,
  output logic [DW-1:0] boot_word
);

  logic          was_in_boot_q;
  logic [DW-1:0] held_q;
  logic          leaving;

  assign leaving   = was_in_boot_q && !pc_in_boot;
  assign boot_word = leaving ? ahead_word : held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      was_in_boot_q <= 1'b1;
      held_q        <= '0;
    end else begin
      was_in_boot_q <= pc_in_boot;
      if (leaving) held_q <= ahead_word;
    end
  end

  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    leaving |=> held_q == $past(ahead_word)); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !leaving |=> $stable(held_q)); // R4

endmodule

// File: rtl/ldal_source_sel.sv
module ldal_source_sel
  import ldal_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int REGION_LSB = 24,
  parameter int REGION_W   = 8,
  parameter int BOOT_BYTES = 16384,
  parameter int CART_OFS_W = 25
) (
  input  logic [AW-1:0]         addr,
  input  logic [1:0]            size,
  input  logic [DW-1:0]         raw,
  input  logic                  pc_in_boot,
  input  logic [DW-1:0]         boot_word,
  input  logic [DW-1:0]         open_word,
  input  logic                  narrow,
  input  logic [CART_OFS_W-1:0] rom_bytes,
  output logic [DW-1:0]         src
);

  localparam int HW = DW / 2;

  logic [REGION_W-1:0] region;
  logic [31:0]         boot_ofs;
  logic                boot_in_range;
  logic                cart_in_range;
  logic                narrow_size;
  src_kind_e           kind;

  assign region        = addr[REGION_LSB +: REGION_W];
  assign boot_ofs      = 32'(addr[REGION_LSB-1:0]);
  assign boot_in_range = boot_ofs < 32'(BOOT_BYTES);
  assign cart_in_range = addr[CART_OFS_W-1:0] < rom_bytes;
  assign narrow_size   = (size == SZ_BYTE) || (size == SZ_HALF);

  always_comb begin
    kind = SRC_RAW;
    if (int'(region) == RG_BOOT) begin
      if (!pc_in_boot)         kind = SRC_BOOT;
      else if (!boot_in_range) kind = SRC_ZERO;
    end else if (int'(region) == RG_HOLE || int'(region) >= RG_MAP_LIMIT) begin
      kind = SRC_OPEN;
    end else if (int'(region) >= RG_CART_LO && int'(region) <= RG_CART_HI) begin
      if (!cart_in_range) kind = SRC_ZERO;
    end
  end

  always_comb begin
    unique case (kind)
      SRC_ZERO: src = '0;
      SRC_BOOT: src = boot_word;
      SRC_OPEN: src = narrow ? {open_word[HW-1:0], open_word[HW-1:0]} : open_word;
      default:  src = (int'(region) == RG_IO && narrow_size) ? {raw[HW-1:0], raw[HW-1:0]} : raw;
    endcase
  end

endmodule

// File: rtl/ldal_shaper.sv
module ldal_shaper
  import ldal_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] src,
  input  logic [1:0]    lane,
  input  logic [1:0]    size,
  input  logic          sgn,
  output logic [DW-1:0] shaped
);

  localparam int HW = DW / 2;
  localparam int LANES = DW / 8;

  logic [7:0]    lane_byte [LANES];
  logic [HW-1:0] half_sel;
  logic [HW-1:0] half_rot;
  logic [7:0]    byte_sel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = src[8*g +: 8];
  end

  assign half_sel = lane[1] ? src[DW-1:HW] : src[HW-1:0];
  assign half_rot = rotr16(half_sel, lane[0]);
  assign byte_sel = lane_byte[lane];

  always_comb begin
    if (size == SZ_BYTE)
      shaped = {{(DW-8){sgn & byte_sel[7]}}, byte_sel};
    else if (size == SZ_HALF)
      shaped = {{(DW-HW){sgn & half_rot[HW-1]}}, half_rot};
    else
      shaped = rotr32(src, lane);
  end

endmodule

// File: rtl/load_aligner.sv
module load_aligner
  import ldal_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int REGION_LSB = 24,
  parameter int REGION_W   = 8,
  parameter int BOOT_BYTES = 16384,
  parameter int CART_OFS_W = 25
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_valid,
  input  logic [AW-1:0]         rd_addr,
  input  logic [1:0]            rd_size,
  input  logic                  rd_signed,
  input  logic [DW-1:0]         rd_raw,
  input  logic [REGION_W-1:0]   pc_region,
  input  logic                  exec_narrow,
  input  logic [DW-1:0]         boot_ahead_word,
  input  logic [DW-1:0]         open_bus_word,
  input  logic [CART_OFS_W-1:0] cart_rom_bytes,
  output logic                  out_valid,
  output logic [DW-1:0]         out_data
);

  logic          pc_in_boot;
  logic [DW-1:0] boot_word;
  logic [DW-1:0] src_word;
  logic [DW-1:0] shaped;

  assign pc_in_boot = (pc_region == '0);

  ldal_boot_latch #(.DW(DW)) i_latch (
    .clk        (clk),
    .rst        (rst),
    .pc_in_boot (pc_in_boot),
    .ahead_word (boot_ahead_word),
    .boot_word  (boot_word)
  );

  ldal_source_sel #(
    .DW(DW), .AW(AW), .REGION_LSB(REGION_LSB), .REGION_W(REGION_W),
    .BOOT_BYTES(BOOT_BYTES), .CART_OFS_W(CART_OFS_W)
  ) i_src (
    .addr       (rd_addr),
    .size       (rd_size),
    .raw        (rd_raw),
    .pc_in_boot (pc_in_boot),
    .boot_word  (boot_word),
    .open_word  (open_bus_word),
    .narrow     (exec_narrow),
    .rom_bytes  (cart_rom_bytes),
    .src        (src_word)
  );

  ldal_shaper #(.DW(DW)) i_shape (
    .src    (src_word),
    .lane   (rd_addr[1:0]),
    .size   (rd_size),
    .sgn    (rd_signed),
    .shaped (shaped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= rd_valid;
      if (rd_valid) out_data <= shaped;
    end
  end

  logic [REGION_W-1:0] chk_region;
  assign chk_region = rd_addr[REGION_LSB +: REGION_W];

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> out_valid); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> (!out_valid && $stable(out_data))); // R11

  AST_PLAIN_WORD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && chk_region == 8'd2 && rd_size == 2'd2 && rd_addr[1:0] == 2'd0)
      |=> out_data == $past(rd_raw)); // R1

  AST_BOOT_PAST_END: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && chk_region == 8'd0 && pc_region == 8'd0
      && 32'(rd_addr[REGION_LSB-1:0]) >= 32'(BOOT_BYTES)) |=> out_data == '0); // R5

  AST_CART_PAST_END: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && chk_region >= 8'd8 && chk_region <= 8'd13
      && rd_addr[CART_OFS_W-1:0] >= cart_rom_bytes) |=> out_data == '0); // R6

  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_size == 2'd0 && !rd_signed) |=> out_data[DW-1:8] == '0); // R9

  AST_HALF_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_size == 2'd1 && rd_signed)
      |=> out_data[DW-1:DW/2] == {(DW/2){out_data[DW/2-1]}}); // R10

endmodule

// File: tb/test_load_aligner.sv
module test_load_aligner;

  logic        clk = 1'b0;
  logic        rst;
  logic        rd_valid;
  logic [31:0] rd_addr;
  logic [1:0]  rd_size;
  logic        rd_signed;
  logic [31:0] rd_raw;
  logic [7:0]  pc_region;
  logic        exec_narrow;
  logic [31:0] boot_ahead_word;
  logic [31:0] open_bus_word;
  logic [24:0] cart_rom_bytes;
  logic        out_valid;
  logic [31:0] out_data;

  always #4 clk = ~clk;

  load_aligner i_load_aligner (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_signed(rd_signed), .rd_raw(rd_raw), .pc_region(pc_region), .exec_narrow(exec_narrow),
    .boot_ahead_word(boot_ahead_word), .open_bus_word(open_bus_word),
    .cart_rom_bytes(cart_rom_bytes), .out_valid(out_valid), .out_data(out_data)
  );

  typedef struct {
    logic        v;
    logic [31:0] d;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [7:0]  nx_pc = 8'd0;
  logic        nx_narrow = 1'b0;
  logic [31:0] nx_ahead = 32'h0;
  logic [31:0] nx_open = 32'h0;
  logic [24:0] nx_rom = 25'h100;
  logic        m_prev_boot = 1'b1;
  logic [31:0] m_held = 32'h0;
  logic [31:0] last_exp = 32'h0;

  function automatic logic [31:0] shape_model(logic [31:0] s, logic [1:0] a, logic [1:0] sz, logic sg);
    logic [7:0] b [4];
    logic [7:0] lo, hi, hb0, hb1;
    logic [31:0] r;
    for (int i = 0; i < 4; i++) b[i] = s[8*i +: 8];
    if (sz == 2'd0) begin
      r = {{24{sg & b[a][7]}}, b[a]};
    end else if (sz == 2'd1) begin
      hb0 = b[{a[1], 1'b0}];
      hb1 = b[{a[1], 1'b1}];
      lo = a[0] ? hb1 : hb0;
      hi = a[0] ? hb0 : hb1;
      r = {{16{sg & hi[7]}}, hi, lo};
    end else begin
      for (int k = 0; k < 4; k++) r[8*k +: 8] = b[(k + int'(a)) % 4];
    end
    return r;
  endfunction

  function automatic logic [31:0] src_model(logic [31:0] a, logic [1:0] sz, logic [31:0] raw, logic [31:0] held_eff);
    int rg;
    rg = int'(a[31:24]);
    if (rg == 0) begin
      if (nx_pc != 8'd0) return held_eff;
      return (a[23:0] >= 24'd16384) ? 32'h0 : raw;
    end
    if (rg == 1 || rg >= 16) return nx_narrow ? {nx_open[15:0], nx_open[15:0]} : nx_open;
    if (rg >= 8 && rg <= 13) return (a[24:0] >= nx_rom) ? 32'h0 : raw;
    if (rg == 4 && sz < 2'd2) return {raw[15:0], raw[15:0]};
    return raw;
  endfunction

  task automatic model_step();
    if (m_prev_boot && nx_pc != 8'd0) m_held = nx_ahead;
    m_prev_boot = (nx_pc == 8'd0);
  endtask

  task automatic apply_ctl();
    pc_region       = nx_pc;
    exec_narrow     = nx_narrow;
    boot_ahead_word = nx_ahead;
    open_bus_word   = nx_open;
    cart_rom_bytes  = nx_rom;
  endtask

  task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic sg,
                       input logic [31:0] raw, input string tag);
    logic [31:0] eff;
    exp_t e;
    @(negedge clk);
    apply_ctl();
    rd_valid = 1'b1; rd_addr = a; rd_size = sz; rd_signed = sg; rd_raw = raw;
    eff = (m_prev_boot && nx_pc != 8'd0) ? nx_ahead : m_held;
    e.v = 1'b1;
    e.d = shape_model(src_model(a, sz, raw, eff), a[1:0], sz, sg);
    e.tag = tag;
    last_exp = e.d;
    sb.push_back(e);
    model_step();
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    apply_ctl();
    rd_valid = 1'b0; rd_raw = 32'hFFFF_FFFF;
    e.v = 1'b0; e.d = last_exp; e.tag = tag;
    sb.push_back(e);
    model_step();
  endtask

  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (out_valid !== e.v || out_data !== e.d) begin
          errors++;
          $display("FAIL %s: valid=%0b data=%08h expected valid=%0b data=%08h",
                   e.tag, out_valid, out_data, e.v, e.d);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; rd_valid = 1'b0; rd_addr = '0; rd_size = '0; rd_signed = 1'b0; rd_raw = '0;
    apply_ctl();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 32'h0) begin
      errors++;
      $display("FAIL R11 reset: valid=%0b data=%08h expected valid=0 data=00000000", out_valid, out_data);
    end

    issue(32'h0200_0000, 2'd2, 1'b0, 32'h1122_3344, "R1 aligned word");
    issue(32'h0200_0001, 2'd2, 1'b1, 32'h1122_3344, "R1 word rotate 8");
    issue(32'h0200_0003, 2'd2, 1'b0, 32'h1122_3344, "R1 word rotate 24");
    issue(32'h0300_0002, 2'd1, 1'b0, 32'h80F1_0203, "R2 R9 upper half");
    issue(32'h0300_0003, 2'd1, 1'b1, 32'h80F1_0203, "R2 R10 upper half rotated signed");
    issue(32'h0300_0001, 2'd1, 1'b1, 32'h80F1_8203, "R2 R10 lower half rotated signed");
    issue(32'h0300_0000, 2'd1, 1'b1, 32'h0000_8203, "R10 half signed negative");
    for (int i = 0; i < 4; i++) begin
      issue(32'h0500_0000 + i, 2'd0, 1'b0, 32'h8833_9A11, $sformatf("R3 R9 byte lane %0d", i));
      issue(32'h0500_0000 + i, 2'd0, 1'b1, 32'h8833_9A11, $sformatf("R3 R10 signed byte lane %0d", i));
    end
    idle("R11 idle hold");
    idle("R11 idle hold 2");

    issue(32'h0000_0100, 2'd2, 1'b0, 32'hB007_C0DE, "R5 boot read inside");
    issue(32'h0000_3FFC, 2'd2, 1'b0, 32'hB007_C0DF, "R5 boot last word");
    issue(32'h0000_4000, 2'd2, 1'b0, 32'hDEAD_BEEF, "R5 boot past end");
    issue(32'h0000_4001, 2'd0, 1'b1, 32'hDEAD_BEEF, "R5 boot past end byte");

    nx_pc = 8'h08; nx_ahead = 32'hCAFE_F00D;
    issue(32'h0000_0000, 2'd2, 1'b0, 32'hDEAD_BEEF, "R4 exit bypass");
    nx_ahead = 32'h1357_9BDF;
    issue(32'h0000_0000, 2'd2, 1'b0, 32'hDEAD_BEEF, "R4 held word");
    issue(32'h0000_0002, 2'd1, 1'b0, 32'hDEAD_BEEF, "R4 held word half");
    nx_pc = 8'h02;
    issue(32'h0000_0001, 2'd0, 1'b0, 32'h0, "R4 held across regions");
    nx_pc = 8'h00;
    idle("R4 return to boot");
    nx_pc = 8'h03;
    issue(32'h0000_0000, 2'd2, 1'b0, 32'hDEAD_BEEF, "R4 second exit");

    nx_rom = 25'h100;
    issue(32'h0800_00FC, 2'd2, 1'b0, 32'hA1B2_C3D4, "R6 cart in range");
    issue(32'h0800_0100, 2'd2, 1'b0, 32'hA1B2_C3D4, "R6 cart at size");
    issue(32'h0D00_0200, 2'd1, 1'b1, 32'hFFFF_FFFF, "R6 cart region 13 beyond");
    issue(32'h0E00_0200, 2'd2, 1'b0, 32'h5555_AAAA, "R6 region 14 passes");

    nx_open = 32'h1234_5678; nx_narrow = 1'b0;
    issue(32'h1000_0000, 2'd2, 1'b0, 32'hFFFF_FFFF, "R7 open bus wide word");
    issue(32'h0100_0001, 2'd0, 1'b0, 32'hFFFF_FFFF, "R7 open bus wide byte");
    nx_open = 32'h9999_ABCD; nx_narrow = 1'b1;
    issue(32'h1000_0000, 2'd2, 1'b0, 32'h0, "R7 open bus narrow word");
    issue(32'h1000_0001, 2'd1, 1'b0, 32'h0, "R7 open bus narrow half");
    issue(32'hFF00_0003, 2'd2, 1'b0, 32'h0, "R7 open bus high region");

    issue(32'h0400_0001, 2'd0, 1'b0, 32'hFFFF_1234, "R8 io high byte");
    issue(32'h0400_0002, 2'd0, 1'b0, 32'hFFFF_1234, "R8 io low byte");
    issue(32'h0400_0003, 2'd1, 1'b0, 32'hFFFF_1284, "R8 io half rotated");
    issue(32'h0400_0000, 2'd2, 1'b0, 32'hFFFF_1234, "R8 io word");
    idle("R11 final idle");
    idle("R11 final idle 2");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule